// File: doc/BRIEF.md
# Two-Wire Master Controller (transaction level)

This block is the master side of a two-wire serial controller, modelled one transaction at a time instead of as wire waveforms. Software drives it through three byte-wide registers: a control register, a data register and a status register. The block turns the software's actions into bus events for an attached target model: STOP, address, write-data and read-data. It collects the target's acknowledge bits and read bytes, and it reports progress as standard 8-bit status codes.

Each status code reaches the status register only after a programmed number of bit-time ticks. When it lands, the interrupt flag is raised. Software then answers by writing one to the interrupt bit, which starts the next phase. A data phase runs only when software has touched the data register since the previous phase: a write phase needs a data-register write, and a read phase needs a data-register read.

Top module: `twm_ctrl`

## Requirements
- R1: After reset the registers read as follows: status 0xF8 (code 0x1F in bits 7:3, prescaler bits 2:0 zero), data 0xFF, control 0x00, and irq low. Register addresses are control = 0, data = 1, status = 2. The control bits are: interrupt bit 7, acknowledge-enable bit 6, start bit 5, stop bit 4, enable bit 2.
- R2: While enabled, a 0-to-1 change of the start bit schedules a status update for exactly START_BITS ticks later. The code is 0x08 when no START is active and 0x10 when one is. The stored peer address is cleared.
- R3: After a START, the first interrupt clear is the address phase. An interrupt clear is a control write with bit 7 = 1 while irq is high, with start = 0 and stop = 0. The phase emits an address event (ev_kind 1) carrying the data-register byte. Bit 0 of that byte set means read. After BYTE_BITS ticks the status is 0x18 or 0x20 for a write, and 0x40 or 0x48 for a read. ACK or NACK is decided by the acknowledge flag when the delay expires.
- R4: A write-direction interrupt clear runs a write data phase only if the data register was written since the last phase. The phase emits a write event (ev_kind 2) carrying the byte. The status is 0x28 on ACK and 0x30 on NACK after BYTE_BITS ticks. Without that write, nothing is emitted and no status follows.
- R5: A read-direction interrupt clear runs a read data phase only if the data register was read since the last phase, or if the phase follows a read address phase. The phase emits a read event (ev_kind 3) with ev_flag equal to the acknowledge-enable bit being written. The status is 0x50 when that bit is 1 and 0x58 when it is 0. A byte returned on tgt_data is loaded into the data register.
- R6: The acknowledge flag is cleared when each address or write event is issued. It is set only by a target reply with acknowledge bit 1, so an event with no reply ends as NACK.
- R7: A 0-to-1 change of the stop bit while a START is active emits a STOP event (ev_kind 0) and returns the block to idle. With no START active, no event is emitted.
- R8: A control write that takes enable from 1 to 0 does all of the following: clears acknowledge-enable, start, stop and the interrupt flag; sets data to 0xFF; sets status to 0xF8 without an interrupt; clears the sequence state and the peer address; and cancels any pending status update.
- R9: Writes to the status register change only the prescaler bits 2:0. The status code is left as it was.
- R10: Delays are counted in tick pulses. At most one status update is pending. A new request replaces the pending one and restarts its count.
- R11: While enable is 0, control writes change only the enable bit, and target replies are ignored.
- R12: irq follows the interrupt flag. The flag is set when a delayed status lands. Writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the read latch on the data address) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |
| ev_valid | output | 1 | Bus event valid, one cycle |
| ev_kind | output | 2 | Event kind: 0 STOP, 1 address, 2 write, 3 read |
| ev_byte | output | 8 | Address or write byte |
| ev_flag | output | 1 | Acknowledge to return on a read event |
| tgt_ack_valid | input | 1 | Target acknowledge reply valid |
| tgt_ack | input | 1 | Target acknowledge bit (1 = ACK) |
| tgt_data_valid | input | 1 | Target read byte valid |
| tgt_data | input | 8 | Target read byte |

## Verification
The bench builds the block with its default delays of three ticks for a START and nine for a byte. It drives every tick by hand, so it can check the cycle just before each update lands and the cycle it lands. It sweeps all four combinations of direction and target acknowledge, and in read direction the acknowledge-enable bit follows the same sweep. The sweep order also makes an ACK left over from one phase precede a phase with no reply, which exercises the flag clearing. The short delays also make it cheap to replace a pending START request partway through its count and to cancel one by disabling.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam int CTRL_INT   = 7;
    localparam int CTRL_ACKEN = 6;
    localparam int CTRL_START = 5;
    localparam int CTRL_STOP  = 4;
    localparam int CTRL_EN    = 2;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_DATA = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RESTART = 8'h10;
    localparam logic [7:0] ST_WA_ACK  = 8'h18;
    localparam logic [7:0] ST_WA_NACK = 8'h20;
    localparam logic [7:0] ST_WD_ACK  = 8'h28;
    localparam logic [7:0] ST_WD_NACK = 8'h30;
    localparam logic [7:0] ST_RA_ACK  = 8'h40;
    localparam logic [7:0] ST_RA_NACK = 8'h48;
    localparam logic [7:0] ST_RD_ACK  = 8'h50;
    localparam logic [7:0] ST_RD_NACK = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    typedef enum logic [1:0] {
        EV_STOP  = 2'd0,
        EV_ADDR  = 2'd1,
        EV_WRITE = 2'd2,
        EV_READ  = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic intf;
        logic acken;
        logic start;
        logic stop;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic started;
        logic addr_done;
        logic wr_latch;
        logic rd_latch;
    } seq_t;

    function automatic logic [4:0] code5(input logic [7:0] c);
        return c[7:3];
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [7:0] v);
        ctrl_t c;
        c.intf  = v[CTRL_INT];
        c.acken = v[CTRL_ACKEN];
        c.start = v[CTRL_START];
        c.stop  = v[CTRL_STOP];
        c.en    = v[CTRL_EN];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_pack(input ctrl_t c);
        logic [7:0] v;
        v = 8'h00;
        v[CTRL_INT]   = c.intf;
        v[CTRL_ACKEN] = c.acken;
        v[CTRL_START] = c.start;
        v[CTRL_STOP]  = c.stop;
        v[CTRL_EN]    = c.en;
        return v;
    endfunction

endpackage

// File: rtl/twm_delay.sv
module twm_delay #(
    parameter int CNT_W  = 4,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [CODE_W-1:0] ack_code,
    input  logic [CODE_W-1:0] nack_code,
    input  logic              cancel,
    input  logic              ack_in,
    output logic              fire,
    output logic [CODE_W-1:0] fire_code
);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] ackc_q;
    logic [CODE_W-1:0] nackc_q;

    assign fire      = busy_q && tick && (cnt_q == CNT_W'(1)) && !load && !cancel;
    assign fire_code = ack_in ? ackc_q : nackc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            ackc_q  <= '0;
            nackc_q <= '0;
        end else if (cancel) begin
            busy_q <= 1'b0;
        end else if (load) begin
            busy_q  <= 1'b1;
            cnt_q   <= load_cnt;
            ackc_q  <= ack_code;
            nackc_q <= nack_code;
        end else if (fire) begin
            busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R10: a pending update holds its count between ticks
    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick && !load && !cancel) |=> (busy_q && $stable(cnt_q)));

    // R10: a new request replaces whatever was pending
    a_r10_reload_replaces: assert property (@(posedge clk) disable iff (rst)
        (load && !cancel) |=> (busy_q && cnt_q == $past(load_cnt)));

endmodule

// File: rtl/twm_ack.sv
module twm_ack (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic rep_valid,
    input  logic rep_bit,
    output logic ack_flag
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ack_flag <= 1'b0;
        end else if (en && rep_valid) begin
            ack_flag <= rep_bit;
        end
    end

endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
    import twm_pkg::*;
#(
    parameter int START_BITS = 3,
    parameter int BYTE_BITS  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       ev_valid,
    output logic [1:0] ev_kind,
    output logic [7:0] ev_byte,
    output logic       ev_flag,
    input  logic       tgt_ack_valid,
    input  logic       tgt_ack,
    input  logic       tgt_data_valid,
    input  logic [7:0] tgt_data
);

    localparam int MAX_BITS = (START_BITS > BYTE_BITS) ? START_BITS : BYTE_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    ctrl_t      ctrl_q;
    seq_t       seq_q;
    logic [7:0] data_q;
    logic [7:0] peer_q;
    logic [4:0] code_q;
    logic [2:0] presc_q;
    logic       ev_valid_q;
    ev_kind_e   ev_kind_q;
    logic [7:0] ev_byte_q;
    logic       ev_flag_q;

    // decode of the software access
    ctrl_t wr_c;
    logic  ctrl_wr, data_wr, data_rd, stat_wr;
    logic  disable_now, active_wr, start_edge, stop_edge, int_clear, phase_go;
    logic  addr_go, wdata_go, rdata_go;

    assign wr_c        = ctrl_unpack(reg_wdata);
    assign ctrl_wr     = reg_wr && reg_addr == ADR_CTRL;
    assign data_wr     = reg_wr && reg_addr == ADR_DATA;
    assign data_rd     = reg_rd && reg_addr == ADR_DATA;
    assign stat_wr     = reg_wr && reg_addr == ADR_STAT;
    assign disable_now = ctrl_wr && ctrl_q.en && !wr_c.en;
    assign active_wr   = ctrl_wr && ctrl_q.en && wr_c.en;
    assign start_edge  = active_wr && wr_c.start && !ctrl_q.start;
    assign stop_edge   = active_wr && wr_c.stop && !ctrl_q.stop;
    assign int_clear   = active_wr && ctrl_q.intf && wr_c.intf;
    assign phase_go    = int_clear && !wr_c.start && !wr_c.stop && seq_q.started;
    assign addr_go     = phase_go && !seq_q.addr_done;
    assign wdata_go    = phase_go && seq_q.addr_done && !peer_q[0] && seq_q.wr_latch;
    assign rdata_go    = phase_go && seq_q.addr_done && peer_q[0] && seq_q.rd_latch;

    // delayed status request
    logic             dl_load;
    logic [CNT_W-1:0] dl_cnt;
    logic [4:0]       dl_ack, dl_nack;
    logic             dly_fire;
    logic [4:0]       dly_code;
    logic             ack_flag;

    assign dl_load = start_edge || addr_go || wdata_go || rdata_go;

    always_comb begin
        dl_cnt  = CNT_W'(BYTE_BITS);
        dl_ack  = code5(ST_IDLE);
        dl_nack = code5(ST_IDLE);
        if (start_edge) begin
            dl_cnt  = CNT_W'(START_BITS);
            dl_ack  = (seq_q.started && !stop_edge) ? code5(ST_RESTART) : code5(ST_START);
            dl_nack = dl_ack;
        end else if (addr_go) begin
            dl_ack  = data_q[0] ? code5(ST_RA_ACK)  : code5(ST_WA_ACK);
            dl_nack = data_q[0] ? code5(ST_RA_NACK) : code5(ST_WA_NACK);
        end else if (wdata_go) begin
            dl_ack  = code5(ST_WD_ACK);
            dl_nack = code5(ST_WD_NACK);
        end else if (rdata_go) begin
            dl_ack  = wr_c.acken ? code5(ST_RD_ACK) : code5(ST_RD_NACK);
            dl_nack = dl_ack;
        end
    end

    twm_delay #(.CNT_W(CNT_W), .CODE_W(5)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (dl_load),
        .load_cnt  (dl_cnt),
        .ack_code  (dl_ack),
        .nack_code (dl_nack),
        .cancel    (disable_now),
        .ack_in    (ack_flag),
        .fire      (dly_fire),
        .fire_code (dly_code)
    );

    twm_ack u_ack (
        .clk       (clk),
        .rst       (rst),
        .clr       (addr_go || wdata_go || disable_now),
        .en        (ctrl_q.en),
        .rep_valid (tgt_ack_valid),
        .rep_bit   (tgt_ack),
        .ack_flag  (ack_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            seq_q      <= '0;
            data_q     <= 8'hFF;
            peer_q     <= 8'h00;
            code_q     <= code5(ST_IDLE);
            presc_q    <= 3'd0;
            ev_valid_q <= 1'b0;
            ev_kind_q  <= EV_STOP;
            ev_byte_q  <= 8'h00;
            ev_flag_q  <= 1'b0;
        end else begin
            ev_valid_q <= 1'b0;
            if (dly_fire) begin
                code_q      <= dly_code;
                ctrl_q.intf <= 1'b1;
            end
            if (tgt_data_valid && ctrl_q.en) data_q <= tgt_data;
            if (data_wr) begin
                data_q         <= reg_wdata;
                seq_q.wr_latch <= 1'b1;
            end
            if (data_rd) seq_q.rd_latch <= 1'b1;
            if (stat_wr) presc_q <= reg_wdata[2:0];
            if (ctrl_wr) begin
                if (!ctrl_q.en) begin
                    ctrl_q.en <= wr_c.en;
                end else if (!wr_c.en) begin
                    ctrl_q <= '0;
                    seq_q  <= '0;
                    data_q <= 8'hFF;
                    peer_q <= 8'h00;
                    code_q <= code5(ST_IDLE);
                end else begin
                    ctrl_q.acken <= wr_c.acken;
                    ctrl_q.start <= wr_c.start;
                    ctrl_q.stop  <= wr_c.stop;
                    if (int_clear) ctrl_q.intf <= 1'b0;
                    if (stop_edge) begin
                        if (seq_q.started) begin
                            ev_valid_q <= 1'b1;
                            ev_kind_q  <= EV_STOP;
                            ev_byte_q  <= peer_q;
                            ev_flag_q  <= 1'b0;
                        end
                        seq_q <= '0;
                    end
                    if (start_edge) begin
                        peer_q <= 8'h00;
                        seq_q  <= '{started: 1'b1, default: 1'b0};
                    end
                    if (phase_go) seq_q.wr_latch <= 1'b0;
                    if (addr_go) begin
                        peer_q          <= data_q;
                        seq_q.addr_done <= 1'b1;
                        seq_q.rd_latch  <= data_q[0];
                        ev_valid_q      <= 1'b1;
                        ev_kind_q       <= EV_ADDR;
                        ev_byte_q       <= data_q;
                        ev_flag_q       <= 1'b0;
                    end
                    if (wdata_go) begin
                        ev_valid_q <= 1'b1;
                        ev_kind_q  <= EV_WRITE;
                        ev_byte_q  <= data_q;
                        ev_flag_q  <= 1'b0;
                    end
                    if (rdata_go) begin
                        seq_q.rd_latch <= 1'b0;
                        ev_valid_q     <= 1'b1;
                        ev_kind_q      <= EV_READ;
                        ev_byte_q      <= peer_q;
                        ev_flag_q      <= wr_c.acken;
                    end
                end
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = ctrl_pack(ctrl_q);
            ADR_DATA: reg_rdata = data_q;
            ADR_STAT: reg_rdata = {code_q, presc_q};
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign irq      = ctrl_q.intf;
    assign ev_valid = ev_valid_q;
    assign ev_kind  = ev_kind_q;
    assign ev_byte  = ev_byte_q;
    assign ev_flag  = ev_flag_q;

    // R2: a start request wipes the stored peer address
    a_r2_start_clears_peer: assert property (@(posedge clk) disable iff (rst)
        start_edge |=> (peer_q == 8'h00));

    // R6: an address or write event always leaves with the flag cleared
    a_r6_event_clears_ack: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind_q == EV_ADDR || ev_kind_q == EV_WRITE)) |-> !ack_flag);

    // R7: stop during a transfer emits STOP and goes idle
    a_r7_stop_goes_idle: assert property (@(posedge clk) disable iff (rst)
        (stop_edge && seq_q.started) |=> (ev_valid && ev_kind_q == EV_STOP && !seq_q.started));

    // R8: disabling resets the visible state and nothing fires afterwards
    a_r8_disable_state: assert property (@(posedge clk) disable iff (rst)
        disable_now |=> (code_q == code5(ST_IDLE) && data_q == 8'hFF && !irq && !dly_fire));

    // R9: a status write never touches the code
    a_r9_status_code_kept: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !dly_fire) |=> $stable(code_q));

    // R12: the interrupt only rises when a delayed status lands
    a_r12_irq_from_update: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(dly_fire));

endmodule

// File: tb/twm_ctrl_tb.sv
module twm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       ev_valid;
    logic [1:0] ev_kind;
    logic [7:0] ev_byte;
    logic       ev_flag;
    logic       tgt_ack_valid = 1'b0;
    logic       tgt_ack = 1'b0;
    logic       tgt_data_valid = 1'b0;
    logic [7:0] tgt_data = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    twm_ctrl dut_i (
        .clk(clk), .rst(rst), .tick(tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte), .ev_flag(ev_flag),
        .tgt_ack_valid(tgt_ack_valid), .tgt_ack(tgt_ack),
        .tgt_data_valid(tgt_data_valid), .tgt_data(tgt_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic reply_ack(input logic b);
        @(negedge clk); tgt_ack_valid = 1'b1; tgt_ack = b;
        @(negedge clk); tgt_ack_valid = 1'b0;
    endtask

    task automatic reply_data(input logic [7:0] b);
        @(negedge clk); tgt_data_valid = 1'b1; tgt_data = b;
        @(negedge clk); tgt_data_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(2'd2, v); chk("R1 status", v, 8'hF8);
        peek(2'd1, v); chk("R1 data", v, 8'hFF);
        peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R9 status write only touches prescaler
        wr(2'd2, 8'hFF); peek(2'd2, v); chk("R9 presc set", v, 8'hFF);
        wr(2'd2, 8'h00); peek(2'd2, v); chk("R9 presc clr", v, 8'hF8);

        // R11 control writes ignored while disabled
        wr(2'd0, 8'h70); peek(2'd0, v); chk("R11 ctrl ignored", v, 8'h00);
        ticks(4); chk("R11 no irq", {7'd0, irq}, 8'h00);
        reply_data(8'h3C); peek(2'd1, v); chk("R11 tgt data ignored", v, 8'hFF);

        wr(2'd0, 8'h04); peek(2'd0, v); chk("R11 enable only", v, 8'h04);

        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < 2; a++) begin
                // R2 start timing
                wr(2'd0, 8'h24);
                ticks(2); chk("R2 not before 3 ticks", {7'd0, irq}, 8'h00);
                ticks(1); chk("R2 irq", {7'd0, irq}, 8'h01);
                peek(2'd2, v); chk("R2 start code", v, 8'h08);

                // R3 address phase
                exp = {7'h2A, 1'(d)};
                wr(2'd1, exp);
                wr(2'd0, 8'h84);
                chk("R3 addr ev", {5'd0, ev_valid, ev_kind}, 8'h05);
                chk("R3 addr byte", ev_byte, exp);
                chk("R12 irq cleared", {7'd0, irq}, 8'h00);
                if (a == 1) reply_ack(1'b1);
                ticks(8); chk("R3 not before 9 ticks", {7'd0, irq}, 8'h00);
                ticks(1); peek(2'd2, v);
                exp = (d == 1) ? ((a == 1) ? 8'h40 : 8'h48) : ((a == 1) ? 8'h18 : 8'h20);
                chk("R3 R6 addr status", v, exp);

                if (d == 0) begin
                    // R4 write data phase
                    wr(2'd1, 8'h5A ^ 8'(a));
                    wr(2'd0, 8'h84);
                    chk("R4 write ev", {5'd0, ev_valid, ev_kind}, 8'h06);
                    chk("R4 write byte", ev_byte, 8'h5A ^ 8'(a));
                    reply_ack(1'(a));
                    ticks(9); peek(2'd2, v);
                    chk("R4 write status", v, (a == 1) ? 8'h28 : 8'h30);
                    // R4 no latch: no phase
                    wr(2'd0, 8'h84);
                    chk("R4 no latch ev", {7'd0, ev_valid}, 8'h00);
                    ticks(9); chk("R4 no latch status", {7'd0, irq}, 8'h00);
                end else begin
                    // R5 read data phase
                    wr(2'd0, 8'h84 | 8'(a << 6));
                    chk("R5 read ev", {4'd0, ev_flag, ev_valid, ev_kind}, {4'd0, 1'(a), 3'b111});
                    reply_data(8'hC3 ^ 8'(a));
                    ticks(9); peek(2'd2, v);
                    chk("R5 read status", v, (a == 1) ? 8'h50 : 8'h58);
                    wr(2'd0, 8'h84);
                    chk("R5 no latch ev", {7'd0, ev_valid}, 8'h00);
                    ticks(9); chk("R5 no latch status", {7'd0, irq}, 8'h00);
                    rd_data(v); chk("R5 read byte", v, 8'hC3 ^ 8'(a));
                end

                // R7 stop
                wr(2'd0, 8'h94);
                chk("R7 stop ev", {5'd0, ev_valid, ev_kind}, 8'h04);
                wr(2'd0, 8'h04);
            end
        end

        // R7 stop while idle
        wr(2'd0, 8'h14); chk("R7 idle stop", {7'd0, ev_valid}, 8'h00);
        wr(2'd0, 8'h04);

        // R2 repeated start, R10 replacement
        wr(2'd0, 8'h24); ticks(3); peek(2'd2, v); chk("R2 start", v, 8'h08);
        wr(2'd2, 8'h05); peek(2'd2, v); chk("R9 presc keep code", v, 8'h0D);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h04); chk("R12 write 0 keeps irq", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'hA4); chk("R12 clear", {7'd0, irq}, 8'h00);
        ticks(1);
        wr(2'd0, 8'h04); wr(2'd0, 8'h24);
        ticks(2); chk("R10 replaced not early", {7'd0, irq}, 8'h00);
        ticks(1); chk("R10 replaced lands", {7'd0, irq}, 8'h01);
        peek(2'd2, v); chk("R2 repeated start", v, 8'h10);
        wr(2'd0, 8'h94); chk("R7 stop after restart", {5'd0, ev_valid, ev_kind}, 8'h04);
        wr(2'd0, 8'h04);

        // R8 disable
        wr(2'd0, 8'h64); ticks(3); chk("R8 pre irq", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h00);
        peek(2'd2, v); chk("R8 status", v, 8'hF8);
        peek(2'd1, v); chk("R8 data", v, 8'hFF);
        peek(2'd0, v); chk("R8 ctrl", v, 8'h00);
        chk("R8 irq", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h04); wr(2'd0, 8'h24); ticks(1);
        wr(2'd0, 8'h00); ticks(5);
        chk("R8 pending cancelled", {7'd0, irq}, 8'h00);
        peek(2'd2, v); chk("R8 status kept", v, 8'hF8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule